// File: doc/BRIEF.md
# Wakeup and Watchdog Reset Supervisor

This block keeps a sleeping microcontroller alive and honest. While the processor is running and regulated, the block produces a periodic wakeup square wave. Each rising edge opens a wakeup cycle. Within that cycle the processor has to answer with a falling edge on its watchdog input. The first such edge pulls the wakeup line low early, and the line stays low until the next cycle opens. If a whole cycle passes without an edge, the block drives its active-low reset output at the end of that cycle.

The block also supervises the supply through a power-good flag. Reset is held while the flag is low. After the flag returns, reset is held for a fixed delay. A missing watchdog edge causes a reset of the same length. The wakeup line is held low for as long as reset is asserted. After reset is released, the first wakeup rising edge follows half a period later.

All intervals come from two parameters. TICK_DIV is the number of clocks in one base tick. PERIOD_TICKS is the wakeup period in ticks and must be even. The reset hold is 12.5 periods and the restart lead is half a period, so both are whole numbers of ticks.

Top module: `wdg_supervisor`

## Requirements
- R1: While `rst` is high, and afterwards for as long as `pwr_ok` stays low, `rst_n` reads 0 and `wake` reads 0.
- R2: After `pwr_ok` rises and stays high, `rst_n` rises exactly 12.5 × PERIOD_TICKS × TICK_DIV clocks plus 3 clocks of input and output latency after the edge on the pin. It rises only if the synchronized flag was high.
- R3: The first `wake` rising edge follows each `rst_n` rising edge by PERIOD_TICKS/2 × TICK_DIV clocks.
- R4: If every cycle contains a watchdog edge that arrives in its low half, `wake` is a 50% square wave with a period of PERIOD_TICKS × TICK_DIV clocks.
- R5: The first falling edge of `wdi` during the high half of a cycle drives `wake` low 4 clocks after the pin edge. `wake` stays low until the next cycle starts, one full period after the cycle's rising edge.
- R6: Further `wdi` falling edges in the same cycle change nothing. None of them counts toward the following cycle.
- R7: A cycle with no `wdi` falling edge ends with `rst_n` going low 1 clock after the period ends. It stays low for 12.5 periods.
- R8: When `pwr_ok` goes low, `rst_n` goes low 4 clocks after the pin edge, whatever the state.
- R9: A loss of `pwr_ok` during the reset hold restarts the full hold once `pwr_ok` returns.
- R10: `wake` is low in every cycle in which `rst_n` is low. A reset that starts while `wake` is high lowers both outputs on the same clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok | input | 1 | Supply in regulation, asynchronous |
| wdi | input | 1 | Watchdog input from the processor, asynchronous, falling edge active |
| wake | output | 1 | Wakeup square wave, registered |
| rst_n | output | 1 | Active-low reset to the processor, registered |

## Verification
The hardest case to reach is a watchdog edge that has to be counted against the right cycle. Two cases matter: a second edge that must not carry into the next cycle, and a late edge in the low half that must still keep the cycle alive. The stimulus waits for the observed `wake` rising edge. It then places each `wdi` pulse a fixed number of clocks after that edge. This lets it put one pulse in the high half and one in the low half of the same cycle, and then leave the next cycle empty. A second hard case is a supply drop inside a reset hold that is already running. The bench drops `pwr_ok` for a few clocks partway through the hold. It expects no release until a full new hold has elapsed.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_LEAD = 2'd1,
    ST_RUN  = 2'd2
  } sup_state_t;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/wdg_sync2.sv
module wdg_sync2 #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  logic [W-1:0] stable;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta   <= {W{RST_VAL}};
      stable <= {W{RST_VAL}};
    end else begin
      meta   <= d;
      stable <= meta;
    end
  end

  assign q = stable;
endmodule

// File: rtl/wdg_fall_det.sv
module wdg_fall_det (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic fall
);
  logic cur;
  logic prev;

  wdg_sync2 #(.W(1), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (din),
    .q   (cur)
  );

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b1;
    else     prev <= cur;
  end

  assign fall = prev & ~cur;
endmodule

// File: rtl/wdg_tick_gen.sv
module wdg_tick_gen #(
  parameter int unsigned DIV = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic tick
);
  localparam int unsigned PW = wdg_pkg::cnt_width(DIV);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      logic [PW-1:0] pre;
      localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

      always_ff @(posedge clk) begin
        if (rst || clr)          pre <= '0;
        else if (pre == PRE_LAST) pre <= '0;
        else                     pre <= pre + PW'(1);
      end

      assign tick = (pre == PRE_LAST);
    end
  endgenerate
endmodule

// File: rtl/wdg_sup_core.sv
module wdg_sup_core
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 1000,
  parameter int unsigned PERIOD_TICKS = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pg_ok,
  input  logic       wd_fall,
  output sup_state_t st,
  output logic       wake_raw,
  output logic       rstn_raw
);
  localparam int unsigned HALF_TICKS = PERIOD_TICKS / 2;
  localparam int unsigned HOLD_TICKS = (PERIOD_TICKS * 25) / 2;
  localparam int unsigned CW         = $clog2(HOLD_TICKS + 1);

  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] LEAD_LAST = CW'(HALF_TICKS - 1);
  localparam logic [CW-1:0] RUN_LAST  = CW'(PERIOD_TICKS - 1);
  localparam logic [CW-1:0] HALF_CNT  = CW'(HALF_TICKS);

  logic          tick;
  sup_state_t    st_n;
  logic [CW-1:0] tcnt, tcnt_n;
  logic          wd_seen, seen_n;
  logic [CW-1:0] lim_last;
  logic          last;

  // prescaler restarts whenever regulation is lost so every interval is exact
  wdg_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .clr  (~pg_ok),
    .tick (tick)
  );

  always_comb begin
    unique case (st)
      ST_HOLD: lim_last = HOLD_LAST;
      ST_LEAD: lim_last = LEAD_LAST;
      default: lim_last = RUN_LAST;
    endcase
  end

  assign last = tick && (tcnt == lim_last);

  always_comb begin
    st_n   = st;
    tcnt_n = tcnt;
    seen_n = wd_seen;
    if (!pg_ok) begin
      st_n   = ST_HOLD;
      tcnt_n = '0;
      seen_n = 1'b0;
    end else begin
      if (tick) tcnt_n = tcnt + CW'(1);
      unique case (st)
        ST_HOLD: begin
          if (last) begin
            st_n   = ST_LEAD;
            tcnt_n = '0;
          end
        end
        ST_LEAD: begin
          if (last) begin
            st_n   = ST_RUN;
            tcnt_n = '0;
            seen_n = 1'b0;
          end
        end
        ST_RUN: begin
          // only the first edge matters; later ones leave the flag set
          seen_n = wd_seen | wd_fall;
          if (last) begin
            st_n   = seen_n ? ST_RUN : ST_HOLD;
            tcnt_n = '0;
            seen_n = 1'b0;
          end
        end
        default: begin
          st_n   = ST_HOLD;
          tcnt_n = '0;
          seen_n = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_HOLD;
      tcnt    <= '0;
      wd_seen <= 1'b0;
    end else begin
      st      <= st_n;
      tcnt    <= tcnt_n;
      wd_seen <= seen_n;
    end
  end

  assign wake_raw = (st == ST_RUN) && (tcnt < HALF_CNT) && !wd_seen;
  assign rstn_raw = (st != ST_HOLD);
endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
  import wdg_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 1000,
  parameter int unsigned PERIOD_TICKS = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic wdi,
  output logic wake,
  output logic rst_n
);
  logic       pg_ok;
  logic       wd_fall;
  sup_state_t st;
  logic       wake_raw;
  logic       rstn_raw;
  logic       wake_q;
  logic       rstn_q;

  wdg_sync2 #(.W(1), .RST_VAL(1'b0)) u_pg_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwr_ok),
    .q   (pg_ok)
  );

  wdg_fall_det u_wd_edge (
    .clk  (clk),
    .rst  (rst),
    .din  (wdi),
    .fall (wd_fall)
  );

  wdg_sup_core #(
    .TICK_DIV     (TICK_DIV),
    .PERIOD_TICKS (PERIOD_TICKS)
  ) u_core (
    .clk      (clk),
    .rst      (rst),
    .pg_ok    (pg_ok),
    .wd_fall  (wd_fall),
    .st       (st),
    .wake_raw (wake_raw),
    .rstn_raw (rstn_raw)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wake_q <= 1'b0;
      rstn_q <= 1'b0;
    end else begin
      wake_q <= wake_raw;
      rstn_q <= rstn_raw;
    end
  end

  assign wake  = wake_q;
  assign rst_n = rstn_q;
endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk
  import wdg_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       pg_ok,
  input logic       wd_fall,
  input sup_state_t st,
  input logic       wake,
  input logic       rst_n
);

  p_wake_low_in_reset_r10: assert property (@(posedge clk) disable iff (rst)
    !rst_n |-> !wake);

  p_pg_loss_r8: assert property (@(posedge clk) disable iff (rst)
    !pg_ok |=> ##1 !rst_n);

  p_release_needs_pg_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> $past(pg_ok, 2));

  p_wd_drops_wake_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN && wd_fall) |=> ##1 (!wake || $rose(wake)));

  p_wake_rise_in_run_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(wake) |-> ($past(st) == ST_RUN && rst_n));

endmodule

bind wdg_supervisor wdg_supervisor_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pg_ok   (pg_ok),
  .wd_fall (wd_fall),
  .st      (st),
  .wake    (wake),
  .rst_n   (rst_n)
);

// File: tb/sim_wdg_supervisor.sv
module sim_wdg_supervisor;
  localparam int TD   = 2;
  localparam int PT   = 8;
  localparam int PER  = TD * PT;
  localparam int HALF = PER / 2;
  localparam int HOLD = ((PT * 25) / 2) * TD;
  localparam int PG_LAT = 3;
  localparam int WD_LAT = 4;

  localparam int K_RST_RISE = 0;
  localparam int K_RST_FALL = 1;
  localparam int K_WK_RISE  = 2;
  localparam int K_WK_FALL  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwr_ok = 1'b0;
  logic wdi = 1'b1;
  wire  wake;
  wire  rst_n;

  wdg_supervisor #(.TICK_DIV(TD), .PERIOD_TICKS(PT)) u0 (
    .clk    (clk),
    .rst    (rst),
    .pwr_ok (pwr_ok),
    .wdi    (wdi),
    .wake   (wake),
    .rst_n  (rst_n)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0;
  int n_err = 0;
  int ref_cyc = 0;
  bit done = 1'b0;

  int    q_kind[$];
  int    q_gap[$];
  string q_tag[$];

  function automatic string kname(input int k);
    case (k)
      K_RST_RISE: return "rst_n rise";
      K_RST_FALL: return "rst_n fall";
      K_WK_RISE:  return "wake rise";
      default:    return "wake fall";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic expect_evt(input int k, input int gap, input string tag);
    q_kind.push_back(k);
    q_gap.push_back(gap);
    q_tag.push_back(tag);
  endtask

  task automatic take_evt(input int k);
    int gap;
    gap = cyc - ref_cyc;
    if (q_kind.size() == 0) begin
      check(1'b0, "R6", {"unexpected ", kname(k)}, gap, -1);
    end else begin
      int    ek;
      int    eg;
      string et;
      ek = q_kind.pop_front();
      eg = q_gap.pop_front();
      et = q_tag.pop_front();
      check(ek == k, et, "event kind", k, ek);
      check(eg == gap, et, {kname(ek), " gap"}, gap, eg);
    end
    ref_cyc = cyc;
  endtask

  // monitor: turns output edges into events and scores them
  logic pw = 1'b0;
  logic pr = 1'b0;
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (rst_n !== pr) begin
        take_evt(rst_n ? K_RST_RISE : K_RST_FALL);
        pr = rst_n;
      end
      if (wake !== pw) begin
        take_evt(wake ? K_WK_RISE : K_WK_FALL);
        pw = wake;
      end
    end
  end

  task automatic wait_rise();
    @(posedge wake);
    @(negedge clk);
  endtask

  task automatic pulse(input int delay, input int hold);
    repeat (delay) @(negedge clk);
    wdi = 1'b0;
    repeat (hold) @(negedge clk);
    wdi = 1'b1;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
      finish_run();
    end
  end

  initial begin
    // R1: reset state and hold while supply is not regulated
    repeat (5) @(negedge clk);
    check(rst_n == 1'b0, "R1", "rst_n during rst", rst_n, 0);
    check(wake == 1'b0, "R1", "wake during rst", wake, 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    check(rst_n == 1'b0, "R1", "rst_n with pwr_ok low", rst_n, 0);
    check(wake == 1'b0, "R1", "wake with pwr_ok low", wake, 0);

    // R2, R3: power-up release then restart lead
    expect_evt(K_RST_RISE, HOLD + PG_LAT, "R2");
    expect_evt(K_WK_RISE, HALF, "R3");
    pwr_ok = 1'b1;
    ref_cyc = cyc;

    // R4: late edges in the low half keep a clean square wave
    for (int i = 0; i < 2; i++) begin
      wait_rise();
      expect_evt(K_WK_FALL, HALF, "R4");
      expect_evt(K_WK_RISE, HALF, "R4");
      pulse(10, 2);
    end

    // R5: early edge cuts the high phase
    wait_rise();
    expect_evt(K_WK_FALL, WD_LAT, "R5");
    expect_evt(K_WK_RISE, PER - WD_LAT, "R5");
    pulse(0, 3);

    // R6: two edges in one cycle, none in the next
    wait_rise();
    expect_evt(K_WK_FALL, WD_LAT, "R6");
    expect_evt(K_WK_RISE, PER - WD_LAT, "R6");
    pulse(0, 2);
    pulse(4, 2);
    wait_rise();
    // R7: missing edge leads to reset at cycle end, full hold
    expect_evt(K_WK_FALL, HALF, "R6");
    expect_evt(K_RST_FALL, HALF, "R7");
    expect_evt(K_RST_FALL == 1 ? K_RST_RISE : K_RST_RISE, HOLD, "R7");
    expect_evt(K_WK_RISE, HALF, "R3");

    // R8, R10: supply loss during the high phase drops both outputs
    wait_rise();
    expect_evt(K_RST_FALL, 1 + WD_LAT, "R8");
    expect_evt(K_WK_FALL, 0, "R10");
    @(negedge clk);
    pwr_ok = 1'b0;
    repeat (20) @(negedge clk);

    // R9: a dip inside the hold restarts it
    pwr_ok = 1'b1;
    repeat (100) @(negedge clk);
    pwr_ok = 1'b0;
    repeat (3) @(negedge clk);
    expect_evt(K_RST_RISE, HOLD + PG_LAT, "R9");
    expect_evt(K_WK_RISE, HALF, "R3");
    pwr_ok = 1'b1;
    ref_cyc = cyc;

    // serviced cycle after recovery
    wait_rise();
    expect_evt(K_WK_FALL, WD_LAT, "R5");
    expect_evt(K_WK_RISE, PER - WD_LAT, "R4");
    pulse(0, 2);
    repeat (16) @(negedge clk);
    check(q_kind.size() == 0, "R4", "pending expected events", q_kind.size(), 0);

    done = 1'b1;
    finish_run();
  end
endmodule